// File: doc/BRIEF.md
# Abstract-Command Argument Register Bank

This block holds the argument and result words that pass between an external debugger and an internal command engine. It has up to twelve 32-bit entries. Each entry has two sides. Side A faces the debugger bus and side B faces the engine. The debugger loads arguments before it starts a command, the engine reads them and writes results back, and the debugger then collects the results.

When `MR_MODE` is 1, each entry is a message register. A word written on one side can only be read from the other side. After a write, the value that was stored for the opposite direction is no longer valid. Reading an invalid value returns the poison word 32'hDEADBEEF. When `MR_MODE` is 0, each entry is one shared word that both sides can read and write. This mode is required when entries are shadowed into a memory map or are used by auto-incrementing memory commands.

While the engine reports a command in progress, the bank guards the debugger side. Debugger writes are dropped. Any debugger access raises a 3-bit error code to 1 (busy), but only if the code is 0 at that time. The debugger clears the code by writing ones to it.

Top module: `msg_data_bank`

## Requirements
- R1: After reset the error code is 0. In message mode every entry reads 32'hDEADBEEF from both sides. In shared mode every entry reads 0.
- R2: In message mode, a debugger write to entry i can be read from the engine side of entry i from the next cycle on.
- R3: In message mode, after a debugger write to entry i, the debugger side of entry i reads 32'hDEADBEEF.
- R4: In message mode, an engine write to entry i can be read from the debugger side of entry i from the next cycle on. After that write, the engine side of entry i reads 32'hDEADBEEF.
- R5: If both sides write the same entry in the same cycle, the engine write takes effect and the debugger write is discarded.
- R6: A debugger access (read or write) while `cmd_busy_i` is 1 sets the error code to 1 on the next cycle, but only if the code is 0.
- R7: A debugger write while `cmd_busy_i` is 1 leaves the entry unchanged on both sides.
- R8: `data_count_o` equals the `NUM_REGS` parameter (12 by default). Entries are numbered upward from 0.
- R9: Engine writes take effect whether or not `cmd_busy_i` is 1.
- R10: Each bit set in `err_clr_i` clears the matching bit of the error code on the next cycle. A set caused by R6 takes priority over a clear in the same cycle.
- R11: An index at or above `NUM_REGS` reads 0 on both sides. Writes to such an index are ignored.
- R12: In shared mode an entry holds one word. The last write from either side can be read from both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_valid_i | input | 1 | Debugger access strobe |
| dbg_write_i | input | 1 | Debugger access is a write |
| dbg_idx_i | input | 4 | Debugger entry index |
| dbg_wdata_i | input | 32 | Debugger write data |
| dbg_rdata_o | output | 32 | Debugger read data (side A, combinational) |
| eng_we_i | input | 1 | Engine write strobe |
| eng_idx_i | input | 4 | Engine entry index |
| eng_wdata_i | input | 32 | Engine write data |
| eng_rdata_o | output | 32 | Engine read data (side B, combinational) |
| cmd_busy_i | input | 1 | Command in progress |
| err_clr_i | input | 3 | Write-one-to-clear strobe for the error code |
| cmd_err_o | output | 3 | Command error code |
| data_count_o | output | 4 | Number of implemented entries |

## Verification
Reads are combinational, so both read ports follow their index input within the same cycle. Writes and error-code changes show up one clock edge after the cycle in which the strobe is seen. The bench drives inputs on the falling edge. It samples read data 1 ns after setting an index in a low phase. It checks the effect of a write or an error update only after the following falling edge, which means exactly one rising edge has passed. A second instance in shared mode takes the same stimulus, so both behaviours are checked against the same sequence.

// File: rtl/msg_bank_pkg.sv
package msg_bank_pkg;
  localparam logic [31:0] POISON   = 32'hDEADBEEF;
  localparam logic [2:0]  ERR_NONE = 3'd0;
  localparam logic [2:0]  ERR_BUSY = 3'd1;
  typedef enum logic [1:0] {HOLD_NONE, HOLD_A, HOLD_B} hold_e;
endpackage

// File: rtl/msg_cell.sv
module msg_cell #(
  parameter int DATA_W  = 32,
  parameter bit MR_MODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic [DATA_W-1:0] wd_a_i,
  input  logic              wr_b_i,
  input  logic [DATA_W-1:0] wd_b_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);
  import msg_bank_pkg::*;
  localparam logic [DATA_W-1:0] POIS = DATA_W'(POISON);

  if (MR_MODE) begin : g_mr
    logic [DATA_W-1:0] val_a_q, val_b_q;
    hold_e             hold_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_a_q <= '0;
        val_b_q <= '0;
        hold_q  <= HOLD_NONE;
      end else if (wr_b_i) begin
        val_b_q <= wd_b_i;
        hold_q  <= HOLD_B;
      end else if (wr_a_i) begin
        val_a_q <= wd_a_i;
        hold_q  <= HOLD_A;
      end
    end

    // side A sees only what B wrote, and vice versa
    assign rd_a_o = (hold_q == HOLD_B) ? val_b_q : POIS;
    assign rd_b_o = (hold_q == HOLD_A) ? val_a_q : POIS;

    // R2 R3
    a_to_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_a_i && !wr_b_i |=> rd_b_o == $past(wd_a_i) && rd_a_o == POIS);
    // R4 R5
    b_to_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_b_i |=> rd_a_o == $past(wd_b_i) && rd_b_o == POIS);
  end else begin : g_trad
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q <= '0;
      else if (wr_b_i) word_q <= wd_b_i;
      else if (wr_a_i) word_q <= wd_a_i;
    end

    assign rd_a_o = word_q;
    assign rd_b_o = word_q;

    // R12
    shared_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_a_i && !wr_b_i |=> rd_a_o == $past(wd_a_i) && rd_b_o == $past(wd_a_i));
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_a_i && !wr_b_i |=> $stable(rd_a_o) && $stable(rd_b_o));
endmodule

// File: rtl/busy_err_ctrl.sv
module busy_err_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dbg_valid_i,
  input  logic       busy_i,
  input  logic [2:0] clr_i,
  output logic [2:0] err_o
);
  import msg_bank_pkg::*;
  logic [2:0] err_q;
  logic       set_busy;

  assign set_busy = dbg_valid_i && busy_i && (err_q == ERR_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= ERR_NONE;
    else if (set_busy) err_q <= ERR_BUSY;
    else               err_q <= err_q & ~clr_i;
  end

  assign err_o = err_q;

  // R6
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_valid_i && busy_i && err_o == 3'd0 |=> err_o == 3'd1);
  // R10
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o != 3'd0 |=> err_o == ($past(err_o) & ~$past(clr_i)));
  // R6 R10
  idle_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dbg_valid_i && busy_i) && clr_i == 3'd0 |=> $stable(err_o));
endmodule

// File: rtl/msg_data_bank.sv
module msg_data_bank #(
  parameter int NUM_REGS = 12,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter bit MR_MODE  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_valid_i,
  input  logic              dbg_write_i,
  input  logic [IDX_W-1:0]  dbg_idx_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  output logic [DATA_W-1:0] dbg_rdata_o,
  input  logic              eng_we_i,
  input  logic [IDX_W-1:0]  eng_idx_i,
  input  logic [DATA_W-1:0] eng_wdata_i,
  output logic [DATA_W-1:0] eng_rdata_o,
  input  logic              cmd_busy_i,
  input  logic [2:0]        err_clr_i,
  output logic [2:0]        cmd_err_o,
  output logic [IDX_W-1:0]  data_count_o
);
  localparam int CNT = NUM_REGS;

  logic [DATA_W-1:0] rd_a [CNT];
  logic [DATA_W-1:0] rd_b [CNT];
  logic              dbg_wr_ok;

  assign dbg_wr_ok    = dbg_valid_i && dbg_write_i && !cmd_busy_i;
  assign data_count_o = IDX_W'(CNT);

  for (genvar i = 0; i < CNT; i++) begin : g_cell
    logic wr_a, wr_b;
    assign wr_a = dbg_wr_ok && (dbg_idx_i == IDX_W'(i));
    assign wr_b = eng_we_i  && (eng_idx_i == IDX_W'(i));

    msg_cell #(.DATA_W(DATA_W), .MR_MODE(MR_MODE)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_a_i (wr_a),
      .wd_a_i (dbg_wdata_i),
      .wr_b_i (wr_b),
      .wd_b_i (eng_wdata_i),
      .rd_a_o (rd_a[i]),
      .rd_b_o (rd_b[i])
    );
  end

  always_comb begin
    dbg_rdata_o = '0;
    eng_rdata_o = '0;
    for (int k = 0; k < CNT; k++) begin
      if (dbg_idx_i == IDX_W'(k)) dbg_rdata_o = rd_a[k];
      if (eng_idx_i == IDX_W'(k)) eng_rdata_o = rd_b[k];
    end
  end

  busy_err_ctrl u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dbg_valid_i (dbg_valid_i),
    .busy_i      (cmd_busy_i),
    .clr_i       (err_clr_i),
    .err_o       (cmd_err_o)
  );

  // R11
  unimpl_dbg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(dbg_idx_i) >= CNT |-> dbg_rdata_o == '0);
  // R11
  unimpl_eng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(eng_idx_i) >= CNT |-> eng_rdata_o == '0);
  // R7
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_valid_i && dbg_write_i && cmd_busy_i && !eng_we_i && 32'(dbg_idx_i) < CNT
    |=> dbg_rdata_o == $past(dbg_rdata_o) || dbg_idx_i != $past(dbg_idx_i));
endmodule

// File: tb/msg_data_bank_test.sv
`timescale 1ns/1ps
module msg_data_bank_test;
  localparam logic [31:0] PZN = 32'hDEADBEEF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dbg_valid = 1'b0, dbg_write = 1'b0;
  logic [3:0]  dbg_idx = '0, eng_idx = '0;
  logic [31:0] dbg_wdata = '0, eng_wdata = '0;
  logic        eng_we = 1'b0, busy = 1'b0;
  logic [2:0]  err_clr = '0;
  logic [31:0] dbg_rdata, eng_rdata, t_dbg_rdata, t_eng_rdata;
  logic [2:0]  cmd_err, t_cmd_err;
  logic [3:0]  data_count, t_data_count;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  msg_data_bank #(.MR_MODE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .dbg_valid_i(dbg_valid), .dbg_write_i(dbg_write),
    .dbg_idx_i(dbg_idx), .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(dbg_rdata),
    .eng_we_i(eng_we), .eng_idx_i(eng_idx), .eng_wdata_i(eng_wdata),
    .eng_rdata_o(eng_rdata), .cmd_busy_i(busy), .err_clr_i(err_clr),
    .cmd_err_o(cmd_err), .data_count_o(data_count));

  msg_data_bank #(.MR_MODE(1'b0)) uut_trad (
    .clk_i(clk), .rst_ni(rst_ni), .dbg_valid_i(dbg_valid), .dbg_write_i(dbg_write),
    .dbg_idx_i(dbg_idx), .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(t_dbg_rdata),
    .eng_we_i(eng_we), .eng_idx_i(eng_idx), .eng_wdata_i(eng_wdata),
    .eng_rdata_o(t_eng_rdata), .cmd_busy_i(busy), .err_clr_i(err_clr),
    .cmd_err_o(t_cmd_err), .data_count_o(t_data_count));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write sampled by one rising edge; returns at the following falling edge
  task automatic dbg_wr(logic [3:0] idx, logic [31:0] d);
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = 1'b1; dbg_idx = idx; dbg_wdata = d;
    @(negedge clk);
    dbg_valid = 1'b0; dbg_write = 1'b0;
  endtask

  task automatic eng_wr(logic [3:0] idx, logic [31:0] d);
    @(negedge clk);
    eng_we = 1'b1; eng_idx = idx; eng_wdata = d;
    @(negedge clk);
    eng_we = 1'b0;
  endtask

  task automatic set_idx(logic [3:0] di, logic [3:0] ei);
    dbg_idx = di; eng_idx = ei;
    #1;
  endtask

  task automatic t_reset;
    check("R1 err", 32'(cmd_err), 32'd0);
    check("R8 count", 32'(data_count), 32'd12);
    set_idx(4'd0, 4'd11);
    check("R1 mr dbg", dbg_rdata, PZN);
    check("R1 mr eng", eng_rdata, PZN);
    check("R1 trad dbg", t_dbg_rdata, 32'd0);
  endtask

  task automatic t_dbg_to_eng;
    dbg_wr(4'd3, 32'h11112222);
    set_idx(4'd3, 4'd3);
    check("R2 eng sees dbg word", eng_rdata, 32'h11112222);
    check("R3 dbg own write poisoned", dbg_rdata, PZN);
  endtask

  task automatic t_eng_to_dbg;
    eng_wr(4'd3, 32'hA5A50F0F);
    set_idx(4'd3, 4'd3);
    check("R4 dbg sees eng word", dbg_rdata, 32'hA5A50F0F);
    check("R4 eng side poisoned", eng_rdata, PZN);
  endtask

  task automatic t_collide;
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = 1'b1; dbg_idx = 4'd5; dbg_wdata = 32'h1;
    eng_we = 1'b1; eng_idx = 4'd5; eng_wdata = 32'h2;
    @(negedge clk);
    dbg_valid = 1'b0; dbg_write = 1'b0; eng_we = 1'b0;
    set_idx(4'd5, 4'd5);
    check("R5 engine wins mr", dbg_rdata, 32'h2);
    check("R5 dbg dropped mr", eng_rdata, PZN);
    check("R5 engine wins trad", t_eng_rdata, 32'h2);
  endtask

  task automatic t_busy;
    busy = 1'b1;
    dbg_wr(4'd3, 32'h00000055);
    check("R6 err set", 32'(cmd_err), 32'd1);
    set_idx(4'd3, 4'd3);
    check("R7 dbg side kept", dbg_rdata, 32'hA5A50F0F);
    check("R7 eng side kept", eng_rdata, PZN);
    eng_wr(4'd4, 32'h00000077);
    set_idx(4'd4, 4'd4);
    check("R9 engine write while busy", dbg_rdata, 32'h00000077);
    busy = 1'b0;
    @(negedge clk);
    err_clr = 3'b111;
    @(negedge clk);
    err_clr = 3'b000;
    check("R10 err cleared", 32'(cmd_err), 32'd0);
    busy = 1'b1;
    dbg_valid = 1'b1;
    @(negedge clk);
    dbg_valid = 1'b0;
    busy = 1'b0;
    check("R6 read access sets err", 32'(cmd_err), 32'd1);
    err_clr = 3'b010;
    @(negedge clk);
    err_clr = 3'b000;
    check("R10 other bit no clear", 32'(cmd_err), 32'd1);
    err_clr = 3'b001;
    @(negedge clk);
    err_clr = 3'b000;
    check("R10 bit0 cleared", 32'(cmd_err), 32'd0);
  endtask

  task automatic t_unimpl;
    dbg_wr(4'd13, 32'h12345678);
    eng_wr(4'd14, 32'h87654321);
    set_idx(4'd13, 4'd14);
    check("R11 dbg unimpl reads 0", dbg_rdata, 32'd0);
    check("R11 eng unimpl reads 0", eng_rdata, 32'd0);
    check("R11 trad unimpl reads 0", t_dbg_rdata, 32'd0);
    set_idx(4'd3, 4'd5);
    check("R11 no alias dbg", dbg_rdata, 32'hA5A50F0F);
  endtask

  task automatic t_trad;
    dbg_wr(4'd2, 32'hCAFE0001);
    set_idx(4'd2, 4'd2);
    check("R12 trad dbg readback", t_dbg_rdata, 32'hCAFE0001);
    check("R12 trad eng reads", t_eng_rdata, 32'hCAFE0001);
    check("R8 trad count", 32'(t_data_count), 32'd12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_dbg_to_eng();
    t_eng_to_dbg();
    t_collide();
    t_busy();
    t_unimpl();
    t_trad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule